// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Sequencer

This block sits on the host side of a write-only three-wire link (active-low select, serial clock, serial data) that feeds a dual 8-bit voltage-output converter. A command arrives on a valid/ready handshake. It carries a register select, one or two 8-bit codes, a speed flag, a power-down flag and a 2-bit reference choice. The block packs the 16-bit word the converter expects and shifts it out most significant bit first. Every edge is timed in system clocks, so the setup, hold and pulse-width limits of the link are met.

A command with the synchronous-update flag set becomes a three-word burst. The first word is a control word carrying speed, power and reference. The second loads the channel B code into the converter's holding buffer. The third writes channel A, which makes the converter move the buffer into channel B in the same update. `busy` stays high for the whole command. A one-cycle `done` pulse marks its end.

The command FSM has six states. SEQ_IDLE accepts a command and moves to SEQ_ONE for a plain command or to SEQ_CFG for a burst. SEQ_CFG, SEQ_BUFB and SEQ_CHA follow each other, one per word. SEQ_ONE and SEQ_CHA each lead to SEQ_DONE, which returns to SEQ_IDLE. Every word state launches one frame and leaves when that frame reports completion. The frame FSM has six states as well. LK_IDLE starts a frame and moves to LK_LEAD (select low, clock high). LK_LEAD goes to LK_LOW. LK_LOW and LK_HIGH alternate, one pair per bit. After the last bit, LK_LOW goes to LK_TAIL (clock high, select still low). LK_TAIL goes to LK_GAP (select high), and LK_GAP returns to LK_IDLE.

Top module: `dac_link_sequencer`

## Requirements
- R1: After reset `link_cs_n`=1, `link_sclk`=1, `cmd_ready`=1, `busy`=0 and `done`=0.
- R2: Each select-low window contains exactly 16 falling edges of `link_sclk`. The bit present at each falling edge is the next word bit, most significant first.
- R3: Word layout: bit15 = select bit 1, bit14 = fast flag, bit13 = power-down flag, bit12 = select bit 0. For selects 00 (channel B plus buffer), 01 (buffer only) and 10 (channel A, buffer to B), bits 11..4 hold the code and bits 3..0 are 0.
- R4: Select 11 is a control word. Its bits 11..2 are 0 and bits 1..0 carry `cmd_ref`; the code input has no effect. Fast, normal power, reference 10 gives 0xD002.
- R5: With `cmd_sync`=1, `cmd_sel` is ignored and three words go out in this order: control (select 11, `cmd_ref`), buffer (select 01, `cmd_val_b`), channel A (select 10, `cmd_val_a`). All three carry the same fast and power-down flags.
- R6: `link_sclk` is high whenever select is high. Each low and high phase lasts at least HALF_CYC system clocks. `link_din` changes only together with a rising `link_sclk` while select is low.
- R7: Select is low for at least LEAD_CYC cycles before the first falling clock edge.
- R8: Between two words, select stays high for at least max(GAP_CYC, HALF_CYC) cycles.
- R9: `cmd_ready` drops the cycle after a command is taken. It stays low until select has returned high after the command's last word. A single-cycle `done` then precedes `cmd_ready` rising. Exactly one `done` is issued per command.
- R10: `cmd_valid` held high while busy takes no command. No word goes out beyond those of accepted commands, and a held command is taken only once `cmd_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_sync | input | 1 | Run the three-word synchronous-update burst |
| cmd_sel | input | 2 | Register select for a single word |
| cmd_val_a | input | 8 | Code for a single word, or channel A in a burst |
| cmd_val_b | input | 8 | Channel B code used in a burst |
| cmd_fast | input | 1 | Speed flag placed in every word |
| cmd_pdown | input | 1 | Power-down flag placed in every word |
| cmd_ref | input | 2 | Reference choice for control words |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| link_cs_n | output | 1 | Link select, active low |
| link_sclk | output | 1 | Link serial clock, idles high |
| link_din | output | 1 | Link serial data |

## Verification
Two events can fall in the same cycle.

The first pair is the data shift and the rising clock edge. The next bit is loaded exactly as the clock returns high. The scoreboard monitor flags any data change that is not paired with a rising edge. It also checks that the bit captured at each falling edge matches the word expected for that command.

The second pair is the return of `cmd_ready` and a command that has been held valid throughout the previous command. Back-to-back commands are issued with valid already high while busy. The monitor then checks that no word is emitted before the new command's expected words are queued. It also checks that the select-high gap between the two commands still meets R8.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        SEL_B_AND_BUF = 2'b00,
        SEL_BUF_ONLY  = 2'b01,
        SEL_A_XFER    = 2'b10,
        SEL_CONTROL   = 2'b11
    } dls_sel_e;

    typedef struct packed {
        dls_sel_e           sel;
        logic [CODE_W-1:0]  code;
        logic               fast;
        logic               pdown;
        logic [1:0]         refsel;
    } dls_word_req_t;

    typedef struct packed {
        logic               sync;
        logic [1:0]         sel;
        logic [CODE_W-1:0]  val_a;
        logic [CODE_W-1:0]  val_b;
        logic               fast;
        logic               pdown;
        logic [1:0]         refsel;
    } dls_cmd_t;

endpackage

// File: rtl/dls_word_pack.sv
module dls_word_pack
    import dls_pkg::*;
(
    input  dls_word_req_t       req,
    output logic [WORD_W-1:0]   word
);
    localparam int CODE_LSB = WORD_W - 4 - CODE_W;

    always_comb begin
        word             = '0;
        word[WORD_W-1]   = req.sel[1];
        word[WORD_W-2]   = req.fast;
        word[WORD_W-3]   = req.pdown;
        word[WORD_W-4]   = req.sel[0];
        if (req.sel == SEL_CONTROL) begin
            word[1:0] = req.refsel;
        end else begin
            word[CODE_LSB +: CODE_W] = req.code;
        end
    end
endmodule

// File: rtl/dls_link_shifter.sv
module dls_link_shifter
    import dls_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int LEAD_CYC = 1,
    parameter int TAIL_CYC = 1,
    parameter int GAP_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   word,
    output logic                idle,
    output logic                frame_done,
    output logic                cs_n,
    output logic                sclk,
    output logic                din
);
    localparam int GAP_EFF = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
    localparam int MAX_A   = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
    localparam int MAX_B   = (TAIL_CYC > GAP_EFF) ? TAIL_CYC : GAP_EFF;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int BIT_W   = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_EFF - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef enum logic [2:0] {
        LK_IDLE, LK_LEAD, LK_LOW, LK_HIGH, LK_TAIL, LK_GAP
    } lk_state_e;

    lk_state_e          state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [WORD_W-1:0]  sr;
    logic [BIT_W-1:0]   nfall;
    logic               cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            LK_IDLE: if (start)    state_nx = LK_LEAD;
            LK_LEAD: if (cnt_zero) state_nx = LK_LOW;
            LK_LOW:  if (cnt_zero) state_nx = (nfall == LAST_BIT) ? LK_TAIL : LK_HIGH;
            LK_HIGH: if (cnt_zero) state_nx = LK_LOW;
            LK_TAIL: if (cnt_zero) state_nx = LK_GAP;
            LK_GAP:  if (cnt_zero) state_nx = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_IDLE;
            cnt   <= '0;
            sr    <= '0;
            nfall <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                LK_IDLE: begin
                    if (start) begin
                        sr    <= word;
                        cnt   <= LEAD_LD;
                        nfall <= '0;
                    end
                end
                LK_LEAD: cnt <= cnt_zero ? HALF_LD : cnt - 1'b1;
                LK_LOW: begin
                    if (cnt_zero) begin
                        nfall <= nfall + 1'b1;
                        if (nfall == LAST_BIT) begin
                            cnt <= TAIL_LD;
                        end else begin
                            cnt <= HALF_LD;
                            sr  <= {sr[WORD_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                LK_HIGH: cnt <= cnt_zero ? HALF_LD : cnt - 1'b1;
                LK_TAIL: cnt <= cnt_zero ? GAP_LD : cnt - 1'b1;
                LK_GAP:  if (!cnt_zero) cnt <= cnt - 1'b1;
            endcase
        end
    end

    always_comb begin
        cs_n       = (state == LK_IDLE) || (state == LK_GAP);
        sclk       = (state != LK_LOW);
        din        = cs_n ? 1'b0 : sr[WORD_W-1];
        idle       = (state == LK_IDLE);
        frame_done = (state == LK_GAP) && cnt_zero;
    end

    // checker state for the link-level properties
    logic               chk_prev_sclk;
    logic               chk_prev_cs;
    logic [BIT_W:0]     chk_falls;
    logic [CNT_W:0]     chk_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_prev_sclk <= 1'b1;
            chk_prev_cs   <= 1'b1;
            chk_falls     <= '0;
            chk_hi        <= (CNT_W+1)'(GAP_EFF);
        end else begin
            chk_prev_sclk <= sclk;
            chk_prev_cs   <= cs_n;
            if (cs_n)
                chk_falls <= '0;
            else if (chk_prev_sclk && !sclk)
                chk_falls <= chk_falls + 1'b1;
            if (!cs_n)
                chk_hi <= '0;
            else if (chk_hi < (CNT_W+1)'(GAP_EFF))
                chk_hi <= chk_hi + 1'b1;
        end
    end

    // R6
    clk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R6
    din_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !chk_prev_cs && !(sclk && !chk_prev_sclk)) |-> (din == $past(din)));

    // R2
    sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !chk_prev_cs) |-> (chk_falls == (BIT_W+1)'(WORD_W)));

    // R8
    select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && chk_prev_cs) |-> (chk_hi >= (CNT_W+1)'(GAP_EFF)));
endmodule

// File: rtl/dac_link_sequencer.sv
module dac_link_sequencer
    import dls_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int LEAD_CYC = 1,
    parameter int TAIL_CYC = 1,
    parameter int GAP_CYC  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_sync,
    input  logic [1:0]  cmd_sel,
    input  logic [7:0]  cmd_val_a,
    input  logic [7:0]  cmd_val_b,
    input  logic        cmd_fast,
    input  logic        cmd_pdown,
    input  logic [1:0]  cmd_ref,
    output logic        busy,
    output logic        done,
    output logic        link_cs_n,
    output logic        link_sclk,
    output logic        link_din
);
    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_ONE, SEQ_CFG, SEQ_BUFB, SEQ_CHA, SEQ_DONE
    } seq_state_e;

    seq_state_e         state, state_nx;
    dls_cmd_t           cmd_q;
    logic               launched;
    logic               sh_idle, sh_done, sh_start;
    dls_word_req_t      req;
    logic [WORD_W-1:0]  word;
    logic               in_word;

    assign in_word  = (state == SEQ_ONE) || (state == SEQ_CFG) ||
                      (state == SEQ_BUFB) || (state == SEQ_CHA);
    assign sh_start = in_word && !launched && sh_idle;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (cmd_valid) state_nx = cmd_sync ? SEQ_CFG : SEQ_ONE;
            SEQ_ONE:  if (launched && sh_done) state_nx = SEQ_DONE;
            SEQ_CFG:  if (launched && sh_done) state_nx = SEQ_BUFB;
            SEQ_BUFB: if (launched && sh_done) state_nx = SEQ_CHA;
            SEQ_CHA:  if (launched && sh_done) state_nx = SEQ_DONE;
            SEQ_DONE: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cmd_q    <= '0;
            launched <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == SEQ_IDLE && cmd_valid) begin
                cmd_q <= '{sync: cmd_sync, sel: cmd_sel, val_a: cmd_val_a,
                           val_b: cmd_val_b, fast: cmd_fast, pdown: cmd_pdown,
                           refsel: cmd_ref};
            end
            if (sh_start)
                launched <= 1'b1;
            else if (sh_done)
                launched <= 1'b0;
        end
    end

    always_comb begin
        req.fast   = cmd_q.fast;
        req.pdown  = cmd_q.pdown;
        req.refsel = cmd_q.refsel;
        req.code   = cmd_q.val_a;
        req.sel    = dls_sel_e'(cmd_q.sel);
        unique case (state)
            SEQ_CFG:  req.sel = SEL_CONTROL;
            SEQ_BUFB: begin
                req.sel  = SEL_BUF_ONLY;
                req.code = cmd_q.val_b;
            end
            SEQ_CHA:  req.sel = SEL_A_XFER;
            SEQ_IDLE, SEQ_ONE, SEQ_DONE: ;
        endcase
    end

    always_comb begin
        cmd_ready = (state == SEQ_IDLE);
        busy      = (state != SEQ_IDLE);
        done      = (state == SEQ_DONE);
    end

    dls_word_pack u_pack (
        .req  (req),
        .word (word)
    );

    dls_link_shifter #(
        .HALF_CYC (HALF_CYC),
        .LEAD_CYC (LEAD_CYC),
        .TAIL_CYC (TAIL_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sh_start),
        .word       (word),
        .idle       (sh_idle),
        .frame_done (sh_done),
        .cs_n       (link_cs_n),
        .sclk       (link_sclk),
        .din        (link_din)
    );

    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R9
    done_single_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_ready && !done));

    // R9
    ready_select_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> link_cs_n);
endmodule

// File: tb/dac_link_sequencer_tb_top.sv
module dac_link_sequencer_tb_top;
    localparam int HALF_CYC = 2;
    localparam int LEAD_CYC = 1;
    localparam int TAIL_CYC = 1;
    localparam int GAP_CYC  = 2;
    localparam int GAP_EFF  = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_sync = 1'b0, cmd_fast = 1'b0, cmd_pdown = 1'b0;
    logic [1:0] cmd_sel = '0, cmd_ref = '0;
    logic [7:0] cmd_val_a = '0, cmd_val_b = '0;
    logic cmd_ready, busy, done, link_cs_n, link_sclk, link_din;

    always #10 clk = ~clk;

    dac_link_sequencer #(
        .HALF_CYC (HALF_CYC), .LEAD_CYC (LEAD_CYC),
        .TAIL_CYC (TAIL_CYC), .GAP_CYC  (GAP_CYC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_sync (cmd_sync),
        .cmd_sel (cmd_sel), .cmd_val_a (cmd_val_a), .cmd_val_b (cmd_val_b),
        .cmd_fast (cmd_fast), .cmd_pdown (cmd_pdown), .cmd_ref (cmd_ref),
        .busy (busy), .done (done),
        .link_cs_n (link_cs_n), .link_sclk (link_sclk), .link_din (link_din)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_accept = 0;
    int n_done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [1:0] sel, input logic [7:0] code,
                                            input logic fast, input logic pd,
                                            input logic [1:0] rf);
        if (sel == 2'b11) return {sel[1], fast, pd, sel[0], 10'b0, rf};
        return {sel[1], fast, pd, sel[0], code, 4'b0};
    endfunction

    // driver: offers a command, keeps valid high until taken, queues expected words
    task automatic send(input logic sync, input logic [1:0] sel, input logic [7:0] a,
                        input logic [7:0] b, input logic fast, input logic pd,
                        input logic [1:0] rf, input string tag);
        @(negedge clk);
        cmd_sync = sync; cmd_sel = sel; cmd_val_a = a; cmd_val_b = b;
        cmd_fast = fast; cmd_pdown = pd; cmd_ref = rf; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        if (sync) begin
            exp_q.push_back(mk_word(2'b11, a, fast, pd, rf)); tag_q.push_back("R5");
            exp_q.push_back(mk_word(2'b01, b, fast, pd, rf)); tag_q.push_back("R5");
            exp_q.push_back(mk_word(2'b10, a, fast, pd, rf)); tag_q.push_back("R5");
        end else begin
            exp_q.push_back(mk_word(sel, a, fast, pd, rf)); tag_q.push_back(tag);
        end
        n_accept++;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready && busy, "R9", {cmd_ready, busy}, 2'b01);
    endtask

    task automatic wait_quiet();
        while (busy || exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    logic p_cs = 1'b1, p_sclk = 1'b1, p_din = 1'b0, done_seen = 1'b0;
    int nbits = 0, lowlen = 0, highlen = 0, leadlen = 0, gaplen = 1000;
    logic [15:0] word = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_seen) begin
                check(!done && cmd_ready, "R9", {done, cmd_ready}, 2'b01);
                done_seen = 1'b0;
            end
            if (done) begin
                n_done++;
                done_seen = 1'b1;
                check(link_cs_n && exp_q.size() == 0, "R9", exp_q.size(), 0);
            end
            if (link_cs_n) begin
                if (!link_sclk) check(1'b0, "R6", link_sclk, 1);
                if (!p_cs) begin
                    check(nbits == 16, "R2", nbits, 16);
                    if (exp_q.size() != 0) begin
                        logic [15:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(word == e, t, word, e);
                    end
                    gaplen = 1;
                end else begin
                    gaplen++;
                end
            end else if (p_cs) begin
                check(gaplen >= GAP_EFF, "R8", gaplen, GAP_EFF);
                check(exp_q.size() != 0, "R10", exp_q.size(), 1);
                nbits = 0; word = '0; leadlen = 1; highlen = 1;
            end else if (p_sclk && !link_sclk) begin
                if (nbits == 0) check(leadlen >= LEAD_CYC, "R7", leadlen, LEAD_CYC);
                else check(highlen >= HALF_CYC, "R6", highlen, HALF_CYC);
                if (link_din != p_din) check(1'b0, "R6", link_din, p_din);
                word = {word[14:0], link_din};
                nbits++;
                lowlen = 1;
            end else if (!p_sclk && link_sclk) begin
                check(lowlen >= HALF_CYC, "R6", lowlen, HALF_CYC);
                highlen = 1;
            end else begin
                if (link_din != p_din) check(1'b0, "R6", link_din, p_din);
                if (link_sclk) begin
                    highlen++;
                    if (nbits == 0) leadlen++;
                end else begin
                    lowlen++;
                end
            end
            p_cs = link_cs_n; p_sclk = link_sclk; p_din = link_din;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(link_cs_n && link_sclk && cmd_ready && !busy && !done, "R1",
              {link_cs_n, link_sclk, cmd_ready, busy, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(link_cs_n && cmd_ready && !busy, "R1", {link_cs_n, cmd_ready, busy}, 3'b110);

        // R4 control word fast, 2.048 V reference code 10 -> 0xD002
        send(1'b0, 2'b11, 8'h00, 8'h00, 1'b1, 1'b0, 2'b10, "R4");
        wait_quiet();
        // R3 value words, several patterns
        send(1'b0, 2'b00, 8'hA5, 8'h00, 1'b0, 1'b0, 2'b00, "R3");
        wait_quiet();
        send(1'b0, 2'b01, 8'hFF, 8'h00, 1'b1, 1'b1, 2'b11, "R3");
        wait_quiet();
        send(1'b0, 2'b10, 8'h01, 8'h00, 1'b0, 1'b0, 2'b00, "R3");
        wait_quiet();
        // R4 control word ignores the code input
        send(1'b0, 2'b11, 8'hFF, 8'h00, 1'b0, 1'b1, 2'b01, "R4");
        wait_quiet();
        // R5 synchronous burst, select input ignored
        send(1'b1, 2'b00, 8'h3C, 8'hC3, 1'b1, 1'b0, 2'b01, "R5");
        wait_quiet();
        // R10 back-to-back: next command offered while busy
        send(1'b0, 2'b10, 8'h80, 8'h00, 1'b1, 1'b0, 2'b00, "R10");
        send(1'b0, 2'b00, 8'h7E, 8'h00, 1'b0, 1'b1, 2'b00, "R10");
        send(1'b1, 2'b11, 8'h00, 8'hFF, 1'b0, 1'b1, 2'b10, "R5");
        wait_quiet();
        repeat (4) @(negedge clk);
        check(n_done == n_accept, "R9", n_done, n_accept);
        check(link_cs_n && cmd_ready && !busy, "R9", {link_cs_n, cmd_ready, busy}, 3'b110);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule